// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the control unit of a small 8-bit accumulator processor. It takes over the bus while an interrupt is entered or left. Hardware event lines set sticky pending flags. A flag turns into a request only when its local enable is set and the global mask bit of the condition-code byte, which this block owns, is clear. At an instruction boundary a qualified request, or a software-interrupt instruction, starts the entry sequence. The block pushes five bytes of processor state onto a byte-wide stack and raises the mask bit. It then reads the 16-bit service address of the chosen source, high byte first, from a table at the top of memory and prefetches the first three program bytes found there.

A return-from-interrupt instruction runs the opposite sequence. Five bytes are popped and the condition-code byte is reloaded from the stack, so the mask bit becomes whatever was saved. The restored accumulator, index-low byte and program counter are handed back to the processor. The upper index byte is never part of the stack frame. Clearing the mask from software inside a service routine lets a later request nest on top of the current frame.

Top module: `irq_seq_top`

## Requirements
- R1: A pending flag sets in the cycle after its event input is high and stays set until its clear input is pulsed. If event and clear are high in the same cycle, the flag ends set. Flags are visible on `pend_o`.
- R2: After reset `ccr_o` is 0x08, so the mask bit (bit 3) is 1. `sp_o` is 0x007F and `busy_o` is 0. While the mask bit is 1, no hardware request starts an entry.
- R3: A pending source whose enable bit is 0 never starts an entry.
- R4: An entry or return starts only in a cycle with `insn_done_i` high. A qualified request waits until then.
- R5: Entry writes five bytes, in this order: PC low, PC high, index low, accumulator, condition-code byte. Each byte is written at the current stack pointer, and the pointer then decrements by one.
- R6: The stacked condition-code byte holds the mask value from before the entry. The mask bit reads 1 once entry completes.
- R7: Among qualified sources the lowest index wins. Its service address is read from 0xFFFE − 2·index (high byte) and the next address (low byte), and is reported on `entry_pc_o` with the index on `entry_src_o`.
- R8: Entry prefetches three bytes from the service address and the two addresses after it. Byte n appears in `prefetch_o[8n+7:8n]` when `entry_done_o` pulses.
- R9: `swi_i` with `insn_done_i` runs the same entry sequence even when the mask is set. It uses source slot 4 (address 0xFFF6).
- R10: `rti_i` with `insn_done_i` pops five bytes in reverse push order. It reloads `ccr_o` from the stack, returns A, index low and PC on the `ret_*` outputs with a `ret_done_o` pulse, and leaves `sp_o` back where it was before entry.
- R11: The upper index byte is not stacked. Exactly five bus writes happen per entry and none happen during return.
- R12: Entry and return do not clear pending flags.
- R13: If the mask is cleared by software inside a service routine, a new qualified request at the next boundary enters again. It stacks below the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_done_i | input | 1 | Current instruction has completed |
| swi_i | input | 1 | Completed instruction is a software interrupt |
| rti_i | input | 1 | Completed instruction is a return from interrupt |
| src_evt_i | input | NSRC | Hardware event per source |
| src_en_i | input | NSRC | Local enable per source |
| src_clr_i | input | NSRC | Write-one-to-clear of pending flags |
| cpu_pc_i | input | 16 | Program counter to stack |
| cpu_a_i | input | 8 | Accumulator to stack |
| cpu_xl_i | input | 8 | Index low byte to stack |
| ccr_we_i | input | 1 | Software write of condition-code byte |
| ccr_wdata_i | input | 8 | Value for that write |
| sp_we_i | input | 1 | Software write of stack pointer |
| sp_wdata_i | input | 16 | Value for that write |
| mem_addr_o | output | 16 | Bus address |
| mem_we_o | output | 1 | Bus byte write |
| mem_re_o | output | 1 | Bus byte read |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle |
| busy_o | output | 1 | Sequence in progress |
| ccr_o | output | 8 | Condition-code byte, mask at bit 3 |
| sp_o | output | 16 | Stack pointer |
| pend_o | output | NSRC | Pending flags |
| entry_done_o | output | 1 | One-cycle pulse at entry end |
| entry_pc_o | output | 16 | Fetched service address |
| entry_src_o | output | 3 | Serviced slot (NSRC means software) |
| prefetch_o | output | 24 | Three prefetched bytes |
| ret_done_o | output | 1 | One-cycle pulse at return end |
| ret_pc_o | output | 16 | Restored program counter |
| ret_a_o | output | 8 | Restored accumulator |
| ret_xl_o | output | 8 | Restored index low byte |

## Verification
Four properties are checked in every cycle. Pending flags never drop without a clear. Each stack write moves the pointer down by exactly one. The mask bit is high right after the last push. No sequence starts without an instruction boundary, or from a masked hardware request. The winner reported by the priority logic is also checked on every cycle. Some behaviours need the scenarios to show them: the byte order on the stack, the service addresses, the prefetched bytes, the values restored by a return, the write count, and nesting. Each of these depends on memory contents that only the bench's memory model holds.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned STACK_BYTES = 5;
  localparam int unsigned FETCH_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VECH,
    ST_VECL,
    ST_FETCH,
    ST_POP
  } seq_st_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned IW  = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic            req_o,
  output logic [IW-1:0]   sel_o
);
  logic [NSRC-1:0] pend_q, pend_n, qual;
  logic [NSRC-1:0] lowmask;

  // event beats clear in the same cycle
  always_comb pend_n = (pend_q & ~clr_i) | evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  assign qual = pend_q & en_i;

  // fixed priority, lowest index first
  always_comb begin
    sel_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual[i]) sel_o = IW'(i);
    end
  end

  assign req_o   = |qual;
  assign pend_o  = pend_q;
  assign lowmask = (NSRC'(1) << sel_o) - NSRC'(1);

  // R1
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

  // R7
  prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (qual[sel_o] && ((qual & lowmask) == '0)));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET  = 16'h007F,
  parameter logic [7:0]        CCR_RESET = 8'h08,
  parameter int unsigned       IBIT      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              ccr_we_i,
  input  logic [7:0]        ccr_wdata_i,
  input  logic              sp_we_i,
  input  logic [ADDR_W-1:0] sp_wdata_i,
  input  logic              set_mask_i,
  input  logic              ccr_ld_i,
  input  logic [7:0]        ccr_ld_val_i,
  input  logic              sp_dec_i,
  input  logic              sp_inc_i,
  output logic [7:0]        ccr_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic [7:0]        ccr_q, ccr_n;
  logic [ADDR_W-1:0] sp_q, sp_n;

  always_comb begin
    ccr_n = ccr_q;
    if (ccr_ld_i)                  ccr_n = ccr_ld_val_i;
    else if (set_mask_i)           ccr_n[IBIT] = 1'b1;
    else if (ccr_we_i && !busy_i)  ccr_n = ccr_wdata_i;
  end

  always_comb begin
    sp_n = sp_q;
    if (sp_dec_i)                 sp_n = sp_q - ADDR_W'(1);
    else if (sp_inc_i)            sp_n = sp_q + ADDR_W'(1);
    else if (sp_we_i && !busy_i)  sp_n = sp_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= CCR_RESET;
      sp_q  <= SP_RESET;
    end else begin
      ccr_q <= ccr_n;
      sp_q  <= sp_n;
    end
  end

  assign ccr_o = ccr_q;
  assign sp_o  = sp_q;

  // R5
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_dec_i |=> (sp_q == $past(sp_q) - ADDR_W'(1)));
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned       NSRC    = 4,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'hFFFE,
  parameter int unsigned       IBIT    = 3,
  localparam int unsigned      IW      = $clog2(NSRC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     insn_done_i,
  input  logic                     swi_i,
  input  logic                     rti_i,
  input  logic                     hw_req_i,
  input  logic [IW-1:0]            hw_sel_i,
  input  logic [ADDR_W-1:0]        cpu_pc_i,
  input  logic [7:0]               cpu_a_i,
  input  logic [7:0]               cpu_xl_i,
  input  logic [7:0]               ccr_i,
  input  logic [ADDR_W-1:0]        sp_i,
  input  logic [7:0]               mem_rdata_i,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic                     mem_we_o,
  output logic                     mem_re_o,
  output logic [7:0]               mem_wdata_o,
  output logic                     set_mask_o,
  output logic                     ccr_ld_o,
  output logic                     sp_dec_o,
  output logic                     sp_inc_o,
  output logic                     busy_o,
  output logic                     entry_done_o,
  output logic [ADDR_W-1:0]        entry_pc_o,
  output logic [IW-1:0]            entry_src_o,
  output logic [FETCH_BYTES*8-1:0] prefetch_o,
  output logic                     ret_done_o,
  output logic [ADDR_W-1:0]        ret_pc_o,
  output logic [7:0]               ret_a_o,
  output logic [7:0]               ret_xl_o
);
  localparam logic [2:0] PUSH_LAST  = 3'(STACK_BYTES - 1);
  localparam logic [2:0] FETCH_LAST = 3'(FETCH_BYTES - 1);

  seq_st_e                  st_q, st_n;
  logic [2:0]               cnt_q, cnt_n;
  logic [IW-1:0]            idx_q, idx_n;
  logic [ADDR_W-1:0]        pc_q, pc_n, tgt_q, tgt_n;
  logic [7:0]               a_q, a_n, xl_q, xl_n;
  logic [FETCH_BYTES*8-1:0] q_q, q_n;
  logic                     edone_q, edone_n, rdone_q, rdone_n;
  logic [ADDR_W-1:0]        rpc_q, rpc_n;
  logic [7:0]               ra_q, ra_n, rxl_q, rxl_n;
  logic [ADDR_W-1:0]        vec_addr;
  logic                     hw_qual;
  logic [7:0]               push_byte;

  assign hw_qual  = hw_req_i && !ccr_i[IBIT];
  assign vec_addr = VEC_TOP - (ADDR_W'(idx_q) << 1);

  always_comb begin
    case (cnt_q)
      3'd0:    push_byte = pc_q[7:0];
      3'd1:    push_byte = pc_q[15:8];
      3'd2:    push_byte = xl_q;
      3'd3:    push_byte = a_q;
      default: push_byte = ccr_i;
    endcase
  end

  always_comb begin
    st_n = st_q;  cnt_n = cnt_q;  idx_n = idx_q;
    pc_n = pc_q;  a_n = a_q;      xl_n = xl_q;
    tgt_n = tgt_q; q_n = q_q;
    rpc_n = rpc_q; ra_n = ra_q;   rxl_n = rxl_q;
    edone_n = 1'b0; rdone_n = 1'b0;
    mem_addr_o = '0; mem_we_o = 1'b0; mem_re_o = 1'b0; mem_wdata_o = '0;
    set_mask_o = 1'b0; ccr_ld_o = 1'b0; sp_dec_o = 1'b0; sp_inc_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (insn_done_i) begin
          if (rti_i) begin
            st_n  = ST_POP;
            cnt_n = '0;
          end else if (swi_i || hw_qual) begin
            st_n  = ST_PUSH;
            cnt_n = '0;
            idx_n = swi_i ? IW'(NSRC) : hw_sel_i;
            pc_n  = cpu_pc_i;
            a_n   = cpu_a_i;
            xl_n  = cpu_xl_i;
          end
        end
      end
      ST_PUSH: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_i;
        mem_wdata_o = push_byte;
        sp_dec_o    = 1'b1;
        cnt_n       = cnt_q + 3'd1;
        if (cnt_q == PUSH_LAST) begin
          set_mask_o = 1'b1;
          st_n       = ST_VECH;
          cnt_n      = '0;
        end
      end
      ST_VECH: begin
        mem_re_o     = 1'b1;
        mem_addr_o   = vec_addr;
        tgt_n[15:8]  = mem_rdata_i;
        st_n         = ST_VECL;
      end
      ST_VECL: begin
        mem_re_o    = 1'b1;
        mem_addr_o  = vec_addr + ADDR_W'(1);
        tgt_n[7:0]  = mem_rdata_i;
        st_n        = ST_FETCH;
        cnt_n       = '0;
      end
      ST_FETCH: begin
        mem_re_o   = 1'b1;
        mem_addr_o = tgt_q + ADDR_W'(cnt_q);
        for (int b = 0; b < FETCH_BYTES; b++) begin
          if (cnt_q == 3'(b)) q_n[b*8 +: 8] = mem_rdata_i;
        end
        cnt_n = cnt_q + 3'd1;
        if (cnt_q == FETCH_LAST) begin
          st_n    = ST_IDLE;
          edone_n = 1'b1;
        end
      end
      ST_POP: begin
        mem_re_o   = 1'b1;
        mem_addr_o = sp_i + ADDR_W'(1);
        sp_inc_o   = 1'b1;
        cnt_n      = cnt_q + 3'd1;
        case (cnt_q)
          3'd0:    ccr_ld_o     = 1'b1;
          3'd1:    ra_n         = mem_rdata_i;
          3'd2:    rxl_n        = mem_rdata_i;
          3'd3:    rpc_n[15:8]  = mem_rdata_i;
          default: begin
            rpc_n[7:0] = mem_rdata_i;
            st_n       = ST_IDLE;
            rdone_n    = 1'b1;
          end
        endcase
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0;
      pc_q <= '0; a_q <= '0; xl_q <= '0; tgt_q <= '0; q_q <= '0;
      rpc_q <= '0; ra_q <= '0; rxl_q <= '0;
      edone_q <= 1'b0; rdone_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; idx_q <= idx_n;
      pc_q <= pc_n; a_q <= a_n; xl_q <= xl_n; tgt_q <= tgt_n; q_q <= q_n;
      rpc_q <= rpc_n; ra_q <= ra_n; rxl_q <= rxl_n;
      edone_q <= edone_n; rdone_q <= rdone_n;
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign entry_done_o = edone_q;
  assign entry_pc_o   = tgt_q;
  assign entry_src_o  = idx_q;
  assign prefetch_o   = q_q;
  assign ret_done_o   = rdone_q;
  assign ret_pc_o     = rpc_q;
  assign ret_a_o      = ra_q;
  assign ret_xl_o     = rxl_q;

  // R6
  mask_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH && cnt_q == PUSH_LAST) |=> ccr_i[IBIT]);

  // R4
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !insn_done_i) |=> (st_q == ST_IDLE));

  // R2
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !swi_i && !rti_i && ccr_i[IBIT]) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int unsigned       NSRC      = 4,
  parameter logic [15:0]       VEC_TOP   = 16'hFFFE,
  parameter logic [15:0]       SP_RESET  = 16'h007F,
  parameter logic [7:0]        CCR_RESET = 8'h08,
  parameter int unsigned       IBIT      = 3,
  localparam int unsigned      IW        = $clog2(NSRC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     insn_done_i,
  input  logic                     swi_i,
  input  logic                     rti_i,
  input  logic [NSRC-1:0]          src_evt_i,
  input  logic [NSRC-1:0]          src_en_i,
  input  logic [NSRC-1:0]          src_clr_i,
  input  logic [15:0]              cpu_pc_i,
  input  logic [7:0]               cpu_a_i,
  input  logic [7:0]               cpu_xl_i,
  input  logic                     ccr_we_i,
  input  logic [7:0]               ccr_wdata_i,
  input  logic                     sp_we_i,
  input  logic [15:0]              sp_wdata_i,
  output logic [15:0]              mem_addr_o,
  output logic                     mem_we_o,
  output logic                     mem_re_o,
  output logic [7:0]               mem_wdata_o,
  input  logic [7:0]               mem_rdata_i,
  output logic                     busy_o,
  output logic [7:0]               ccr_o,
  output logic [15:0]              sp_o,
  output logic [NSRC-1:0]          pend_o,
  output logic                     entry_done_o,
  output logic [15:0]              entry_pc_o,
  output logic [IW-1:0]            entry_src_o,
  output logic [FETCH_BYTES*8-1:0] prefetch_o,
  output logic                     ret_done_o,
  output logic [15:0]              ret_pc_o,
  output logic [7:0]               ret_a_o,
  output logic [7:0]               ret_xl_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic          hw_req, set_mask, ccr_ld, sp_dec, sp_inc;
  logic [IW-1:0] hw_sel;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  irq_pend #(.NSRC(NSRC)) i_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(src_evt_i), .en_i(src_en_i),
    .clr_i(src_clr_i), .pend_o(pend_o), .req_o(hw_req), .sel_o(hw_sel)
  );

  irq_regs #(.SP_RESET(SP_RESET), .CCR_RESET(CCR_RESET), .IBIT(IBIT)) i_regs (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_o),
    .ccr_we_i(ccr_we_i), .ccr_wdata_i(ccr_wdata_i),
    .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i),
    .set_mask_i(set_mask), .ccr_ld_i(ccr_ld), .ccr_ld_val_i(mem_rdata_i),
    .sp_dec_i(sp_dec), .sp_inc_i(sp_inc), .ccr_o(ccr_o), .sp_o(sp_o)
  );

  irq_seq_fsm #(.NSRC(NSRC), .VEC_TOP(VEC_TOP), .IBIT(IBIT)) i_fsm (
    .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done_i), .swi_i(swi_i),
    .rti_i(rti_i), .hw_req_i(hw_req), .hw_sel_i(hw_sel),
    .cpu_pc_i(cpu_pc_i), .cpu_a_i(cpu_a_i), .cpu_xl_i(cpu_xl_i),
    .ccr_i(ccr_o), .sp_i(sp_o), .mem_rdata_i(mem_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_wdata_o(mem_wdata_o), .set_mask_o(set_mask), .ccr_ld_o(ccr_ld),
    .sp_dec_o(sp_dec), .sp_inc_o(sp_inc), .busy_o(busy_o),
    .entry_done_o(entry_done_o), .entry_pc_o(entry_pc_o),
    .entry_src_o(entry_src_o), .prefetch_o(prefetch_o),
    .ret_done_o(ret_done_o), .ret_pc_o(ret_pc_o), .ret_a_o(ret_a_o),
    .ret_xl_o(ret_xl_o)
  );
endmodule

// File: tb/test_irq_seq_top.sv
module test_irq_seq_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        insn_done = 0, swi = 0, rti = 0;
  logic [3:0]  evt = 0, en = 0, clr = 0;
  logic [15:0] pc = 0;
  logic [7:0]  a = 0, xl = 0;
  logic        ccr_we = 0, sp_we = 0;
  logic [7:0]  ccr_wd = 0;
  logic [15:0] sp_wd = 0;
  logic [15:0] maddr, entry_pc, ret_pc, sp;
  logic        mwe, mre, busy, edone, rdone;
  logic [7:0]  mwd, mrd, ccr, ret_a, ret_xl;
  logic [3:0]  pend;
  logic [2:0]  esrc;
  logic [23:0] pf;

  logic [7:0] mem [256];
  int checks = 0, errors = 0, wr_cnt = 0, cyc = 0;

  always #2.5 clk = ~clk;

  irq_seq_top i_irq_seq_top (
    .clk(clk), .rst_ni(rst_ni), .insn_done_i(insn_done), .swi_i(swi), .rti_i(rti),
    .src_evt_i(evt), .src_en_i(en), .src_clr_i(clr), .cpu_pc_i(pc), .cpu_a_i(a),
    .cpu_xl_i(xl), .ccr_we_i(ccr_we), .ccr_wdata_i(ccr_wd), .sp_we_i(sp_we),
    .sp_wdata_i(sp_wd), .mem_addr_o(maddr), .mem_we_o(mwe), .mem_re_o(mre),
    .mem_wdata_o(mwd), .mem_rdata_i(mrd), .busy_o(busy), .ccr_o(ccr), .sp_o(sp),
    .pend_o(pend), .entry_done_o(edone), .entry_pc_o(entry_pc), .entry_src_o(esrc),
    .prefetch_o(pf), .ret_done_o(rdone), .ret_pc_o(ret_pc), .ret_a_o(ret_a),
    .ret_xl_o(ret_xl)
  );

  assign mrd = mem[maddr[7:0]];

  function automatic logic [7:0] pbyte(input int ad);
    return 8'(ad) ^ 8'h5A;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pbyte(i);
    for (int k = 0; k < 5; k++) begin
      mem[8'hFE - 2*k] = 8'h10 + 8'(k);
      mem[8'hFF - 2*k] = 8'h20 + 8'(16*k);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mwe) begin
      mem[maddr[7:0]] <= mwd;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ccr(input logic [7:0] v);
    ccr_we = 1; ccr_wd = v; tick(1); ccr_we = 0;
  endtask

  task automatic pulse_evt(input logic [3:0] e);
    evt = e; tick(1); evt = 0; tick(1);
  endtask

  task automatic boundary(input logic s, input logic r);
    insn_done = 1; swi = s; rti = r; tick(1);
    insn_done = 0; swi = 0; rti = 0;
  endtask

  task automatic wait_entry(input string req);
    int n = 0;
    while (!edone && n < 40) begin tick(1); n++; end
    if (n >= 40) check({req, " entry timeout"}, 0, 1);
  endtask

  task automatic wait_ret(input string req);
    int n = 0;
    while (!rdone && n < 40) begin tick(1); n++; end
    if (n >= 40) check({req, " return timeout"}, 0, 1);
  endtask

  // per row: events, enables, expected slot
  localparam logic [3:0] T_EVT [5] = '{4'b0110, 4'b1100, 4'b1011, 4'b1000, 4'b0101};
  localparam logic [3:0] T_EN  [5] = '{4'b1111, 4'b0111, 4'b1110, 4'b1000, 4'b1111};
  localparam int         T_EXP [5] = '{1, 2, 1, 3, 0};

  initial begin
    int w0;
    tick(3); rst_ni = 1; tick(3);
    // R2 reset state
    check("R2 ccr", ccr, 8'h08);
    check("R2 sp", sp, 16'h007F);
    check("R2 busy", busy, 0);
    check("R1 pend reset", pend, 0);

    // R2 masked request ignored
    en = 4'b0001; pulse_evt(4'b0001);
    boundary(0, 0); tick(1);
    check("R2 masked no entry", busy, 0);
    clr = 4'hF; tick(1); clr = 0;

    // R3 disabled source ignored
    wr_ccr(8'h00); en = 4'b0000; pulse_evt(4'b0010);
    boundary(0, 0); tick(1);
    check("R3 disabled no entry", busy, 0);
    check("R1 flag held", pend, 4'b0010);

    // R4 waits for boundary
    en = 4'b0010; tick(4);
    check("R4 no entry before boundary", busy, 0);
    pc = 16'h2345; a = 8'h11; xl = 8'h22;
    boundary(0, 0);
    wait_entry("R4");
    check("R4 src", esrc, 1);
    boundary(0, 1); wait_ret("R4");
    clr = 4'hF; tick(1); clr = 0; tick(1);

    // table walk: R5 R6 R7 R8 R10 R11 R12
    for (int t = 0; t < 5; t++) begin
      wr_ccr(8'h00);
      en = T_EN[t];
      pc = 16'h1000 + 16'(t * 16'h0111); a = 8'h30 + 8'(t); xl = 8'h40 + 8'(t);
      pulse_evt(T_EVT[t]);
      w0 = wr_cnt;
      boundary(0, 0);
      wait_entry("R7");
      check("R7 src", esrc, T_EXP[t]);
      check("R7 vector", entry_pc, {8'h10 + 8'(T_EXP[t]), 8'h20 + 8'(16*T_EXP[t])});
      for (int b = 0; b < 3; b++)
        check("R8 prefetch", pf[b*8 +: 8], pbyte(32'h20 + 16*T_EXP[t] + b));
      check("R5 pcl", mem[8'h7F], pc[7:0]);
      check("R5 pch", mem[8'h7E], pc[15:8]);
      check("R5 xl", mem[8'h7D], xl);
      check("R5 a", mem[8'h7C], a);
      check("R6 stacked ccr", mem[8'h7B], 8'h00);
      check("R6 mask set", ccr[3], 1);
      check("R5 sp", sp, 16'h007A);
      check("R11 writes", wr_cnt - w0, 5);
      w0 = wr_cnt;
      boundary(0, 1);
      wait_ret("R10");
      check("R10 pc", ret_pc, pc);
      check("R10 a", ret_a, a);
      check("R10 xl", ret_xl, xl);
      check("R10 ccr", ccr, 8'h00);
      check("R10 sp", sp, 16'h007F);
      check("R11 no return writes", wr_cnt - w0, 0);
      check("R12 pend kept", pend, T_EVT[t]);
      clr = 4'hF; tick(1); clr = 0; tick(1);
    end

    // R9 software interrupt while masked
    wr_ccr(8'h08); en = 4'hF; pc = 16'hBEEF; a = 8'h5; xl = 8'h6;
    boundary(1, 0); wait_entry("R9");
    check("R9 src", esrc, 4);
    check("R9 vector", entry_pc, 16'h1460);
    check("R9 prefetch", pf[7:0], pbyte(32'h60));
    check("R9 stacked ccr", mem[8'h7B], 8'h08);
    boundary(0, 1); wait_ret("R9");
    check("R10 mask restored set", ccr, 8'h08);

    // R1 event wins over clear
    evt = 4'b1000; clr = 4'b1000; tick(1); evt = 0; clr = 0; tick(1);
    check("R1 event beats clear", pend, 4'b1000);
    clr = 4'b1000; tick(1); clr = 0; tick(1);
    check("R1 cleared", pend, 0);

    // R13 nesting
    wr_ccr(8'h00); en = 4'hF; pc = 16'h3000;
    pulse_evt(4'b0100);
    boundary(0, 0); wait_entry("R13");
    check("R13 outer src", esrc, 2);
    clr = 4'b0100; tick(1); clr = 0;
    wr_ccr(8'h00); pc = 16'h3100;
    pulse_evt(4'b0001);
    boundary(0, 0); wait_entry("R13");
    check("R13 inner src", esrc, 0);
    check("R13 sp", sp, 16'h0075);
    check("R13 inner pcl", mem[8'h7A], 8'h00);
    clr = 4'hF; tick(1); clr = 0;
    boundary(0, 1); wait_ret("R13");
    check("R13 inner ret pc", ret_pc, 16'h3100);
    check("R13 sp after inner", sp, 16'h007A);
    boundary(0, 1); wait_ret("R13");
    check("R13 outer ret pc", ret_pc, 16'h3000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected below 20000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule